// File: doc/BRIEF.md
# Convertible Packet Buffer Controller

This block owns one dual-port RAM of 256 words of 64 bits. The RAM changes role as a packet moves through it. In the fill phase it is a FIFO: words arrive on a valid/ready stream, and a flag marks the final word. Once the packet is complete, the same RAM becomes the data memory of an attached processor. The processor reads and writes it by absolute address, and the first word of the packet sits at address 0.

When the processor raises its end signal, the block enters the drain phase. It streams the possibly modified packet out on a second valid/ready stream, in arrival order, and flags the final word. After the final word is taken, the block returns to the fill phase ready for the next packet. A three-state sequencer controls the phases: fill, process, drain. The processor gets a one-cycle start pulse when the process phase begins.

Top module: `cfifo_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, the block is in the fill phase. `in_ready` is 1, `out_valid` is 0 and `proc_start` is 0, and both the fill count and the read pointer are 0.
- R2: In the fill phase, each word accepted (`in_valid` and `in_ready` both high at a clock edge) is stored at the next address, starting from address 0. The processor later sees word k of the packet at address k.
- R3: `in_ready` is 0 in the process and drain phases. A word offered there is not stored and does not extend the packet.
- R4: The processor port is used only in the process phase. `proc_rdata` returns, one cycle after the request, the word at the `proc_addr` presented in that request. If the same cycle writes that address, it returns the newly written data. A write presented in any other phase changes nothing.
- R5: Accepting a word with `in_last` = 1 moves the block to the process phase. `proc_start` is 1 for exactly the first cycle of that phase.
- R6: `proc_end` = 1 in the process phase moves the block to the drain phase. `out_valid` is 1 only in the drain phase. There `out_data` is the word at the read pointer, which starts at 0 and advances by one on each cycle with `out_ready` = 1.
- R7: `out_last` is 1 exactly while the read pointer equals the packet length minus one. Taking that word returns the block to the fill phase with both pointers at 0, so the next packet again starts at address 0.
- R8: A packet that reaches 256 words without `in_last` is closed by its 256th word, exactly as if that word carried `in_last`.
- R9: A one-word packet is handled: its only word is drained with `out_last` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 64 | Incoming packet word |
| in_valid | input | 1 | Incoming word present |
| in_last | input | 1 | Incoming word is the packet's final word |
| in_ready | output | 1 | Block accepts a word (fill phase only) |
| out_data | output | 64 | Outgoing packet word |
| out_valid | output | 1 | Outgoing word present (drain phase only) |
| out_last | output | 1 | Outgoing word is the final word |
| out_ready | input | 1 | Downstream takes the outgoing word |
| proc_addr | input | 8 | Processor word address |
| proc_wdata | input | 64 | Processor write data |
| proc_we | input | 1 | Processor write enable |
| proc_rdata | output | 64 | Processor read data, one cycle after the address |
| proc_start | output | 1 | One-cycle pulse at entry to the process phase |
| proc_end | input | 1 | Processor has finished with the buffer |

## Verification
The assertions assume the following about the inputs:
- the downstream may stall at any time, so held output words must stay stable;
- `proc_end` is given only while the processor owns the buffer;
- no packet is longer than the buffer.

The stimulus keeps within these limits:
- It raises `proc_end` only after the start pulse.
- It sends packets of 1, 2 and 3 words, and one of exactly 256 words with no end flag.
- It inserts random gaps in `in_valid` and random stalls in `out_ready`.
- It deliberately drives processor writes and input words outside their phases, to show that they are ignored.

// File: rtl/cfifo_pkg.sv
package cfifo_pkg;

    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_PROC  = 2'd1,
        ST_DRAIN = 2'd2
    } cf_mode_e;

endpackage

// File: rtl/cfifo_ram.sv
module cfifo_ram #(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 256,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] dout_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // read is registered; a same-cycle write to the read address is forwarded
    always_ff @(posedge clk) begin
        if (we && (waddr == raddr)) begin
            dout_q <= wdata;
        end else begin
            dout_q <= mem_q[raddr];
        end
    end

    assign rdata = dout_q;

endmodule

// File: rtl/cfifo_portmux.sv
module cfifo_portmux #(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 256,
    localparam int AW    = $clog2(DEPTH)
) (
    input  cfifo_pkg::cf_mode_e mode,
    input  logic              fill_we,
    input  logic [AW-1:0]     fill_addr,
    input  logic [DATA_W-1:0] in_data,
    input  logic [AW-1:0]     drain_addr_next,
    input  logic [AW-1:0]     proc_addr,
    input  logic [DATA_W-1:0] proc_wdata,
    input  logic              proc_we,
    input  logic              proc_end,
    output logic              ram_we,
    output logic [AW-1:0]     ram_waddr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic [AW-1:0]     ram_raddr
);
    import cfifo_pkg::*;

    always_comb begin
        ram_we    = 1'b0;
        ram_waddr = fill_addr;
        ram_wdata = in_data;
        ram_raddr = drain_addr_next;
        unique case (mode)
            ST_FILL: begin
                ram_we = fill_we;
            end
            ST_PROC: begin
                ram_we    = proc_we;
                ram_waddr = proc_addr;
                ram_wdata = proc_wdata;
                // on the handover cycle prefetch the first drain word instead
                ram_raddr = proc_end ? drain_addr_next : proc_addr;
            end
            default: begin
                ram_we = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cfifo_seq.sv
module cfifo_seq #(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic                in_last,
    input  logic                out_ready,
    input  logic                proc_end,
    output cfifo_pkg::cf_mode_e mode,
    output logic                in_ready,
    output logic                out_valid,
    output logic                out_last,
    output logic                proc_start,
    output logic                fill_we,
    output logic [AW-1:0]       fill_addr,
    output logic [AW-1:0]       drain_addr_next
);
    import cfifo_pkg::*;

    typedef struct packed {
        cf_mode_e        mode;
        logic [CW-1:0]   cnt;
        logic [AW-1:0]   rd;
        logic            start;
    } seq_t;

    localparam seq_t SEQ_RST = '{mode: ST_FILL, cnt: '0, rd: '0, start: 1'b0};

    seq_t q, d;
    logic at_tail;

    always_comb begin
        at_tail = ({1'b0, q.rd} == (q.cnt - CW'(1)));
        d       = q;
        d.start = 1'b0;
        unique case (q.mode)
            ST_FILL: begin
                if (in_valid) begin
                    d.cnt = q.cnt + CW'(1);
                    if (in_last || (q.cnt == CW'(DEPTH - 1))) begin
                        d.mode  = ST_PROC;
                        d.start = 1'b1;
                    end
                end
            end
            ST_PROC: begin
                if (proc_end) begin
                    d.mode = ST_DRAIN;
                    d.rd   = '0;
                end
            end
            ST_DRAIN: begin
                if (out_ready) begin
                    if (at_tail) begin
                        d = SEQ_RST;
                    end else begin
                        d.rd = q.rd + AW'(1);
                    end
                end
            end
            default: begin
                d = SEQ_RST;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= SEQ_RST;
        end else begin
            q <= d;
        end
    end

    assign mode            = q.mode;
    assign in_ready        = (q.mode == ST_FILL);
    assign out_valid       = (q.mode == ST_DRAIN);
    assign out_last        = (q.mode == ST_DRAIN) && at_tail;
    assign proc_start      = q.start;
    assign fill_we         = (q.mode == ST_FILL) && in_valid;
    assign fill_addr       = q.cnt[AW-1:0];
    assign drain_addr_next = d.rd;

    p_start_single_r5: assert property (@(posedge clk) disable iff (rst)
        proc_start |=> !proc_start);

    p_start_after_accept_r5: assert property (@(posedge clk) disable iff (rst)
        proc_start |-> $past(in_valid && in_ready));

    p_no_accept_outside_fill_r3: assert property (@(posedge clk) disable iff (rst)
        (q.mode == ST_PROC) |=> $stable(q.cnt));

    p_enter_drain_r6: assert property (@(posedge clk) disable iff (rst)
        ((q.mode == ST_PROC) && proc_end) |=> (out_valid && !in_ready));

    p_back_to_fill_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> (in_ready && !out_valid && (q.cnt == '0)));

    p_hold_on_stall_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(q.rd) && $stable(out_last)));

endmodule

// File: rtl/cfifo_ctrl.sv
module cfifo_ctrl #(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 256,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_last,
    input  logic              out_ready,
    input  logic [AW-1:0]     proc_addr,
    input  logic [DATA_W-1:0] proc_wdata,
    input  logic              proc_we,
    output logic [DATA_W-1:0] proc_rdata,
    output logic              proc_start,
    input  logic              proc_end
);
    import cfifo_pkg::*;

    cf_mode_e          mode;
    logic              fill_we;
    logic [AW-1:0]     fill_addr;
    logic [AW-1:0]     drain_addr_next;
    logic              ram_we;
    logic [AW-1:0]     ram_waddr;
    logic [DATA_W-1:0] ram_wdata;
    logic [AW-1:0]     ram_raddr;
    logic [DATA_W-1:0] ram_rdata;

    cfifo_seq #(.DEPTH(DEPTH)) u_seq (
        .clk             (clk),
        .rst             (rst),
        .in_valid        (in_valid),
        .in_last         (in_last),
        .out_ready       (out_ready),
        .proc_end        (proc_end),
        .mode            (mode),
        .in_ready        (in_ready),
        .out_valid       (out_valid),
        .out_last        (out_last),
        .proc_start      (proc_start),
        .fill_we         (fill_we),
        .fill_addr       (fill_addr),
        .drain_addr_next (drain_addr_next)
    );

    cfifo_portmux #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mux (
        .mode            (mode),
        .fill_we         (fill_we),
        .fill_addr       (fill_addr),
        .in_data         (in_data),
        .drain_addr_next (drain_addr_next),
        .proc_addr       (proc_addr),
        .proc_wdata      (proc_wdata),
        .proc_we         (proc_we),
        .proc_end        (proc_end),
        .ram_we          (ram_we),
        .ram_waddr       (ram_waddr),
        .ram_wdata       (ram_wdata),
        .ram_raddr       (ram_raddr)
    );

    cfifo_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    assign out_data   = ram_rdata;
    assign proc_rdata = ram_rdata;

    p_write_forward_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == ST_PROC && !proc_end && proc_we && (proc_addr == ram_raddr))
            |=> (proc_rdata == $past(proc_wdata)));

    p_no_write_outside_r4: assert property (@(posedge clk) disable iff (rst)
        (mode != ST_PROC && !(in_valid && in_ready)) |-> !ram_we);

endmodule

// File: tb/tb_cfifo_ctrl.sv
module tb_cfifo_ctrl;

    localparam int  CLK_PERIOD = 10;
    localparam int  DW         = 64;
    localparam int  DEPTH      = 256;
    localparam int  AW         = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [DW-1:0] in_data;
    logic          in_valid, in_last, in_ready;
    logic [DW-1:0] out_data;
    logic          out_valid, out_last, out_ready;
    logic [AW-1:0] proc_addr;
    logic [DW-1:0] proc_wdata, proc_rdata;
    logic          proc_we, proc_start, proc_end;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfifo_ctrl dut (
        .clk(clk), .rst(rst),
        .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_last(out_last), .out_ready(out_ready),
        .proc_addr(proc_addr), .proc_wdata(proc_wdata), .proc_we(proc_we),
        .proc_rdata(proc_rdata), .proc_start(proc_start), .proc_end(proc_end)
    );

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // mode: 0 fill, 1 process, 2 drain
    int            m_mode;
    int            m_cnt;
    int            m_rd;
    bit            m_start;
    bit            m_prd_valid;
    logic [DW-1:0] m_prd_val;
    logic [DW-1:0] m_mem [DEPTH];
    int            n_out;

    always @(posedge clk) begin
        if (out_valid && out_ready) n_out++;
        if (rst) begin
            m_mode = 0; m_cnt = 0; m_rd = 0; m_start = 0; m_prd_valid = 0;
        end else begin
            m_start     = 0;
            m_prd_valid = 0;
            case (m_mode)
                0: if (in_valid) begin
                    m_mem[m_cnt] = in_data;
                    m_cnt++;
                    if (in_last || m_cnt == DEPTH) begin
                        m_mode = 1; m_start = 1;
                    end
                end
                1: begin
                    if (!proc_end) begin
                        m_prd_valid = 1;
                        m_prd_val   = (proc_we) && (proc_addr == proc_addr) ? proc_wdata : m_mem[proc_addr];
                        if (!proc_we) m_prd_val = m_mem[proc_addr];
                    end
                    if (proc_we) m_mem[proc_addr] = proc_wdata;
                    if (proc_end) begin
                        m_mode = 2; m_rd = 0;
                    end
                end
                default: if (out_ready) begin
                    if (m_rd == m_cnt - 1) begin
                        m_mode = 0; m_cnt = 0; m_rd = 0;
                    end else begin
                        m_rd++;
                    end
                end
            endcase
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk(in_ready == (m_mode == 0), "R3 in_ready", DW'(in_ready), DW'(m_mode == 0));
            chk(proc_start == m_start, "R5 proc_start", DW'(proc_start), DW'(m_start));
            chk(out_valid == (m_mode == 2), "R6 out_valid", DW'(out_valid), DW'(m_mode == 2));
            if (m_mode == 2) begin
                chk(out_data === m_mem[m_rd], "R6 out_data", out_data, m_mem[m_rd]);
                chk(out_last == (m_rd == m_cnt - 1), "R7 out_last", DW'(out_last), DW'(m_rd == m_cnt - 1));
            end
            if (m_prd_valid)
                chk(proc_rdata === m_prd_val, "R4 proc_rdata", proc_rdata, m_prd_val);
        end
    end

    // ---------------- stimulus ----------------
    logic [DW-1:0] sent [DEPTH];

    task automatic send_packet(input int len, input bit use_last);
        for (int i = 0; i < len; i++) begin
            sent[i] = {$urandom, $urandom};
            forever begin
                @(negedge clk);
                in_data  = sent[i];
                in_last  = use_last && (i == len - 1);
                in_valid = (($urandom % 4) != 0);
                if (in_valid && in_ready) break;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic proc_read_chk(input int addr, input logic [DW-1:0] exp, input string tag);
        proc_addr = AW'(addr);
        proc_we   = 1'b0;
        @(negedge clk);
        chk(proc_rdata === exp, tag, proc_rdata, exp);
    endtask

    task automatic drain_all(input int exp_len, input string tag, input bit stall);
        int start_n;
        start_n = n_out;
        forever begin
            out_ready = stall ? (($urandom % 3) != 0) : 1'b1;
            @(negedge clk);
            if (in_ready) break;
        end
        out_ready = 1'b0;
        chk((n_out - start_n) == exp_len, tag, DW'(n_out - start_n), DW'(exp_len));
    endtask

    initial begin
        rst = 1'b1; in_data = '0; in_valid = 0; in_last = 0; out_ready = 0;
        proc_addr = '0; proc_wdata = '0; proc_we = 0; proc_end = 0;
        n_out = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(in_ready == 1'b1, "R1 in_ready", DW'(in_ready), 1);
        chk(out_valid == 1'b0, "R1 out_valid", DW'(out_valid), 0);
        chk(proc_start == 1'b0, "R1 proc_start", DW'(proc_start), 0);

        // Packet A: 3 words; processor write during fill must be ignored (R4)
        proc_we = 1'b1; proc_addr = 8'd5; proc_wdata = 64'hDEAD_BEEF_0000_0005;
        send_packet(3, 1'b1);
        proc_we = 1'b0;
        // now in process phase; offer input words that must be ignored (R3)
        in_valid = 1'b1; in_data = 64'h1111; in_last = 1'b1;
        proc_read_chk(0, sent[0], "R2 word0");
        proc_read_chk(2, sent[2], "R2 word2");
        proc_read_chk(1, sent[1], "R2 word1");
        in_valid = 1'b0; in_last = 1'b0;
        // same-cycle write and read of one address returns new data (R4)
        proc_addr = 8'd1; proc_we = 1'b1; proc_wdata = 64'hA5A5_0000_0000_0001;
        @(negedge clk);
        chk(proc_rdata === 64'hA5A5_0000_0000_0001, "R4 forward", proc_rdata, 64'hA5A5_0000_0000_0001);
        proc_we = 1'b0;
        proc_read_chk(1, 64'hA5A5_0000_0000_0001, "R4 readback");
        // end with a final write to address 0
        proc_addr = 8'd0; proc_we = 1'b1; proc_wdata = 64'h0F0F_0F0F_0000_0000; proc_end = 1'b1;
        @(negedge clk);
        proc_end = 1'b0; proc_we = 1'b1; proc_addr = 8'd2; proc_wdata = 64'h2222; // ignored in drain (R4)
        drain_all(3, "R6 drain length A", 1'b1);
        proc_we = 1'b0;

        // Packet B: one word (R9)
        send_packet(1, 1'b1);
        proc_end = 1'b1;
        @(negedge clk);
        proc_end = 1'b0;
        drain_all(1, "R9 single word", 1'b1);

        // Packet C: 256 words without last flag (R8)
        send_packet(DEPTH, 1'b0);
        chk(in_ready == 1'b0, "R8 closed at capacity", DW'(in_ready), 0);
        proc_read_chk(DEPTH - 1, sent[DEPTH - 1], "R8 word255");
        proc_read_chk(0, sent[0], "R2 word0 C");
        proc_end = 1'b1;
        @(negedge clk);
        proc_end = 1'b0;
        drain_all(DEPTH, "R8 drain length", 1'b0);

        // Packet D: pointers restart at 0 (R7)
        send_packet(2, 1'b1);
        proc_read_chk(0, sent[0], "R7 restart word0");
        proc_read_chk(1, sent[1], "R7 restart word1");
        proc_end = 1'b1;
        @(negedge clk);
        proc_end = 1'b0;
        drain_all(2, "R7 drain length D", 1'b1);

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule